// File: doc/BRIEF.md
# Prescaled Receive Glitch Filter

This block cleans up an asynchronous serial receive line before it reaches a bit decoder. The raw line first passes through a resynchronising flop chain. Its level is then compared against the current filtered level. A new level is accepted only after it has disagreed with the filtered level for a fixed number of consecutive sample ticks. Any shorter excursion is dropped.

The sample ticks come from a programmable divider on the module clock. A 3-bit select sets the divide ratio, so one filter setting can give a worst-case delay from 16 to 128 module clocks. Over a 2 to 20 MHz clock range, this keeps the rejected pulse width in the microsecond range.

Each accepted change of the filtered level raises a strobe for one module clock. A receiver can use that strobe to start edge-based timing.

Top module: `rxf_glitch_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the filtered output is high (recessive) and the edge strobe is low.
- R2: Select code n (000 to 111) makes the sample divider tick once every n+1 module clocks: 000 divides by 1 and 111 divides by 8.
- R3: With the select steady at divide ratio d, a raw level change held long enough appears at the filtered output between 15d+3 and 16d+2 rising clock edges after it is applied. For d=1 this is exactly 18 edges.
- R4: At divide-by-1, a raw pulse away from the filtered level that lasts 15 clocks is ignored. One that lasts 16 clocks is passed on.
- R5: Any return of the synchronised input to the filtered level restarts the stability count. Two 10-clock pulses separated by one clock at the old level therefore never change the output at divide-by-1.
- R6: A change of the select never changes the filtered output by itself. It takes effect only at the divider's next wrap, so a change from 111 to 000 applied together with a raw change gives a delay of 18 to 23 edges.
- R7: The edge strobe is high for exactly one module clock, in the same cycle the filtered output first shows its new level, for both rising and falling changes.
- R8: The raw input reaches the filter only through a two-flop synchroniser. The stability count does not start before the third clock edge after the raw change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| rx_raw_i | input | 1 | Asynchronous raw receive line |
| div_sel_i | input | 3 | Sample divider select; ratio is code plus one |
| rx_filt_o | output | 1 | Filtered receive level, high after reset |
| rx_edge_o | output | 1 | One-clock strobe on each filtered transition |

## Verification
A stability counter that fails to clear would let short glitches add up. This shows as a spurious edge strobe within a few tens of clocks of the second glitch. A divider that counts the wrong ratio or loads the select early moves the delay from raw change to filtered change outside its window on the very next transition. An edge strobe that is misaligned or doubled shows in the same clock as the level change, because the strobe is compared against the filtered level in every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam logic RXF_IDLE_LEVEL = 1'b1;

   function automatic int unsigned rxf_ratio(input int unsigned code);
      return code + 1;
   endfunction
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
   parameter int   STAGES    = 2,
   parameter logic RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rxf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{RST_LEVEL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

   // R8: the output follows the raw input STAGES clocks later
   assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n, STAGES) |-> (q_o == $past(d_i, STAGES)));
endmodule

// File: rtl/rxf_prescaler.sv
module rxf_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   if (SEL_W < 1) begin : g_bad_sel
      $error("rxf_prescaler: SEL_W must be at least 1");
   end

   logic [SEL_W-1:0] div_q;
   logic [SEL_W-1:0] ratio_q;

   assign tick_o = (div_q == ratio_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q   <= '0;
         ratio_q <= '0;
      end else if (tick_o) begin
         div_q   <= '0;
         ratio_q <= sel_i;
      end else begin
         div_q   <= div_q + 1'b1;
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      div_q <= ratio_q);

   assert_sel_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_o |=> $stable(ratio_q));
endmodule

// File: rtl/rxf_stability.sv
module rxf_stability #(
   parameter int   TICKS     = 16,
   parameter logic RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   input  logic tick_i,
   output logic lvl_o,
   output logic edge_o
);
   localparam int CNT_W = (TICKS > 2) ? $clog2(TICKS) : 1;

   if (TICKS < 2) begin : g_bad_ticks
      $error("rxf_stability: TICKS must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             lvl_q;
   logic             edge_q;
   logic             last_tick;

   if ((1 << CNT_W) == TICKS) begin : g_pow2
      assign last_tick = &cnt_q;
   end else begin : g_any
      assign last_tick = (cnt_q == CNT_W'(TICKS - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lvl_q  <= RST_LEVEL;
         edge_q <= 1'b0;
      end else begin
         edge_q <= 1'b0;
         if (rx_i == lvl_q) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            if (last_tick) begin
               cnt_q  <= '0;
               lvl_q  <= ~lvl_q;
               edge_q <= 1'b1;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign lvl_o  = lvl_q;
   assign edge_o = edge_q;

   assert_flip_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> $past(tick_i));

   assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_i == lvl_q) |=> (cnt_q == '0));

   assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_q |=> !edge_q);

   assert_edge_marks_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_q == (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/rxf_glitch_filter.sv
module rxf_glitch_filter #(
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TICKS  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_raw_i,
   input  logic [SEL_W-1:0] div_sel_i,
   output logic             rx_filt_o,
   output logic             rx_edge_o
);
   import rxf_pkg::*;

   logic rx_sync;
   logic tick;

   rxf_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(RXF_IDLE_LEVEL)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(rx_raw_i), .q_o(rx_sync));

   rxf_prescaler #(.SEL_W(SEL_W)) u_div (
      .clk(clk), .rst_n(rst_n), .sel_i(div_sel_i), .tick_o(tick));

   rxf_stability #(.TICKS(FILT_TICKS), .RST_LEVEL(RXF_IDLE_LEVEL)) u_stab (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_sync), .tick_i(tick),
      .lvl_o(rx_filt_o), .edge_o(rx_edge_o));

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (rx_filt_o == RXF_IDLE_LEVEL) && !rx_edge_o);
endmodule

// File: tb/sim_rxf_glitch_filter.sv
module sim_rxf_glitch_filter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       raw = 1'b1;
   logic [2:0] sel = 3'd0;
   logic       filt, edge_s;

   int checks = 0;
   int fails  = 0;
   logic exp_q[$];
   logic prev_lvl;

   always #4 clk = ~clk;

   rxf_glitch_filter u0 (.clk(clk), .rst_n(rst_n), .rx_raw_i(raw),
      .div_sel_i(sel), .rx_filt_o(filt), .rx_edge_o(edge_s));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: scoreboard pop on every strobe, plus strobe/level consistency (R7)
   always @(negedge clk) begin
      if (!rst_n) prev_lvl <= filt;
      else begin
         if (edge_s != (filt != prev_lvl))
            check(0, "R7 strobe vs level change", edge_s, filt != prev_lvl);
         if (edge_s) begin
            if (exp_q.size() == 0) check(0, "R7 unexpected edge", filt, prev_lvl);
            else begin
               logic e;
               e = exp_q.pop_front();
               check(filt == e, "R7 edge level", filt, e);
            end
         end
         prev_lvl <= filt;
      end
   end

   // driver: apply a level (and optionally a new select), time the response
   task automatic measure(input logic v, input bit new_sel, input logic [2:0] s,
                          input int lo, input int hi, input string tag);
      int n;
      @(negedge clk);
      raw = v;
      if (new_sel) sel = s;
      exp_q.push_back(v);
      n = 0;
      do begin
         @(posedge clk); n++;
         @(negedge clk);
      end while (filt != v && n < 400);
      check(n >= lo && n <= hi, tag, n, lo);
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse(input int len);
      @(negedge clk);
      raw = 1'b0;
      repeat (len) @(negedge clk);
      raw = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check(filt == 1'b1, "R1 filt in reset", filt, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(filt == 1'b1, "R1 filt after reset", filt, 1);
      check(edge_s == 1'b0, "R1 edge after reset", edge_s, 0);
      repeat (4) @(negedge clk);

      // R2 / R3: delay windows at ratios 1, 4, 8
      measure(1'b0, 0, 3'd0, 18, 18, "R3 R2 d1 fall");
      measure(1'b1, 0, 3'd0, 18, 18, "R3 R2 d1 rise");
      sel = 3'd3; repeat (10) @(negedge clk);
      measure(1'b0, 0, 3'd0, 63, 66, "R3 R2 d4 fall");
      measure(1'b1, 0, 3'd0, 63, 66, "R3 R2 d4 rise");
      sel = 3'd7; repeat (10) @(negedge clk);
      measure(1'b0, 0, 3'd0, 123, 130, "R3 R2 d8 fall");
      measure(1'b1, 0, 3'd0, 123, 130, "R3 R2 d8 rise");

      // R6: select change alone leaves output untouched
      sel = 3'd0; repeat (30) @(negedge clk);
      check(filt == 1'b1, "R6 select change no effect", filt, 1);
      sel = 3'd7; repeat (12) @(negedge clk);
      measure(1'b0, 1, 3'd0, 18, 23, "R6 select at wrap");
      measure(1'b1, 0, 3'd0, 18, 18, "R6 new ratio active");

      // R4 / R8: glitch width boundary at divide-by-1
      pulse(15); repeat (40) @(negedge clk);
      check(filt == 1'b1, "R4 R8 15-clock pulse ignored", filt, 1);
      exp_q.push_back(1'b0); exp_q.push_back(1'b1);
      pulse(16); repeat (60) @(negedge clk);
      check(filt == 1'b1, "R4 16-clock pulse back high", filt, 1);
      check(exp_q.size() == 0, "R4 16-clock pulse passed", exp_q.size(), 0);

      // R5: interrupted disagreement restarts count
      pulse(10); pulse(10); repeat (40) @(negedge clk);
      check(filt == 1'b1, "R5 restart on return", filt, 1);

      check(exp_q.size() == 0, "R7 all edges seen", exp_q.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule